// File: doc/BRIEF.md
# Self-synchronising idle-lock descrambler

This block recovers plain NRZ bits from a scrambled 100BASE-TX serial stream, one bit per symbol clock. After reset it knows nothing about the far-end scrambler state. It assumes the line carries idle, which is all ones before scrambling. Under that assumption it rebuilds the key stream from the received bits, and then confirms the guess by checking for a long run of descrambled ones before it declares lock.

Once locked, it presents every descrambled bit with a valid flag. A hold timer checks that the lock is still good. Each time the descrambled stream shows a long enough run of ones, the timer restarts. If the timer runs out first, the block discards everything and seeds again from scratch. The hold length and the idle-run threshold are parameters, so that a bench can use short windows.

Top module: `fx_descrambler`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `locked_o`, `ud_valid_o` and `ud_o` are 0.
- R2: The key bit is k(t) = k(t-11) XOR k(t-9), which is the polynomial x^11 + x^9 + 1. The descrambled bit is the received bit XOR k(t). It appears on `ud_o` one clock after the received bit is sampled.
- R3: After reset, and after every restart, the first 11 received bits are taken as key bits under the assumption that the plain bit is 1. Each such key bit is the inverted received bit.
- R4: After seeding, `locked_o` rises on the clock that samples the 60th consecutive descrambled one (`ACQ_ONES`). With idle from reset, this is the clock of bit index 70.
- R5: A descrambled zero during the ones check discards the check. Seeding restarts with the next received bit.
- R6: `ud_valid_o` is 1 only for bits descrambled while locked. It is 0 for the bit sampled on the clock that locks, and for the bit sampled on the clock that drops lock.
- R7: On entry to lock, the hold timer is loaded with `HOLD_BITS`. If no qualifying idle run follows, lock drops on the clock that samples bit index (entry bit + `HOLD_BITS`).
- R8: When a run of `IDLE_MIN` consecutive descrambled ones completes while locked, the timer reloads to `HOLD_BITS`. Each further one in the same run reloads it again.
- R9: When the timer expires, the block returns to seeding. Lock comes back only after a complete new seeding and a new run of `ACQ_ONES` ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_i | input | 1 | Scrambled NRZ bit |
| ud_o | output | 1 | Descrambled bit, registered; 0 when not valid |
| ud_valid_o | output | 1 | `ud_o` carries a bit descrambled under lock |
| locked_o | output | 1 | Descrambler is locked |

## Verification
The assertions take for granted that the stream is contiguous, with one new bit on every clock and no gaps. They also take for granted that the far-end scrambler uses the same recurrence, so that a correct seed always yields the plain bits. The bench therefore builds each scrambled stream from its own key-stream recurrence and a known seed, and applies the stream bit by bit from the cycle reset is released. The seeding window always sees plain ones, so that the expected lock, drop and reload bits can be worked out by arithmetic. Zeros are placed in the plain stream only where they test a restart, or where they prevent a timer reload.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
  typedef enum logic [1:0] {
    ST_SEED  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } acq_state_e;
endpackage

// File: rtl/dscr_keygen.sv
// Key-stream generator: shifts in seed bits or its own feedback.
module dscr_keygen #(
  parameter int W   = 11,
  parameter int TAP = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic seed_en,
  input  logic seed_bit,
  input  logic adv,
  output logic key
);
  logic [W-1:0] s_q;

  // s_q[i] holds the key bit from i+1 bit times ago
  assign key = s_q[W-1] ^ s_q[TAP-1];

  always_ff @(posedge clk) begin
    if (rst)          s_q <= '0;
    else if (seed_en) s_q <= {s_q[W-2:0], seed_bit};
    else if (adv)     s_q <= {s_q[W-2:0], key};
  end

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    seed_en |=> s_q[0] == $past(seed_bit));
  // R2
  keystep_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !seed_en) |=> (s_q[0] == $past(key)) && (s_q[W-1:1] == $past(s_q[W-2:0])));
endmodule

// File: rtl/dscr_run_cnt.sv
// Saturating counter of consecutive ones.
module dscr_run_cnt #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_i,
  output logic reach
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] run_q, run_nx;

  always_comb begin
    if (!bit_i)                   run_nx = '0;
    else if (run_q == CW'(LIMIT)) run_nx = CW'(LIMIT);
    else                          run_nx = run_q + 1'b1;
  end

  assign reach = en && bit_i && (run_nx == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr) run_q <= '0;
    else if (en)    run_q <= run_nx;
  end

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= CW'(LIMIT));
  // R5
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !bit_i) |=> run_q == '0);
endmodule

// File: rtl/dscr_hold_timer.sv
// Lock hold countdown; reloads on load or reload, and flags expiry.
module dscr_hold_timer #(
  parameter int HOLD = 90250
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  input  logic reload,
  output logic expire
);
  localparam int TW = $clog2(HOLD + 1);
  logic [TW-1:0] t_q;

  assign expire = en && !reload && !load && (t_q == TW'(1));

  always_ff @(posedge clk) begin
    if (rst)                 t_q <= '0;
    else if (load || reload) t_q <= TW'(HOLD);
    else if (en)             t_q <= t_q - 1'b1;
  end

  // R7
  timer_live_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> t_q != '0);
  // R7
  timer_range_chk: assert property (@(posedge clk) disable iff (rst)
    t_q <= TW'(HOLD));
  // R8
  timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
    reload |=> t_q == TW'(HOLD));
endmodule

// File: rtl/fx_descrambler.sv
module fx_descrambler
  import dscr_pkg::*;
#(
  parameter int LFSR_W    = 11,
  parameter int LFSR_TAP  = 9,
  parameter int ACQ_ONES  = 60,
  parameter int IDLE_MIN  = 58,
  parameter int HOLD_BITS = 90250
) (
  input  logic clk,
  input  logic rst,
  input  logic sd_i,
  output logic ud_o,
  output logic ud_valid_o,
  output logic locked_o
);
  localparam int SCW = $clog2(LFSR_W);

  acq_state_e     state_q, state_nx;
  logic [SCW-1:0] seed_cnt_q;
  logic key, ud_raw;
  logic in_seed, in_chk, in_lock;
  logic acq_reach, mon_reach, expire, enter_lock, seed_last;

  assign in_seed   = (state_q == ST_SEED);
  assign in_chk    = (state_q == ST_CHECK);
  assign in_lock   = (state_q == ST_LOCK);
  assign ud_raw    = sd_i ^ key;
  assign seed_last = (seed_cnt_q == SCW'(LFSR_W - 1));

  dscr_keygen #(.W(LFSR_W), .TAP(LFSR_TAP)) u_key (
    .clk(clk), .rst(rst), .seed_en(in_seed), .seed_bit(~sd_i),
    .adv(!in_seed), .key(key));

  dscr_run_cnt #(.LIMIT(ACQ_ONES)) u_acq (
    .clk(clk), .rst(rst), .clr(!in_chk), .en(in_chk),
    .bit_i(ud_raw), .reach(acq_reach));

  dscr_run_cnt #(.LIMIT(IDLE_MIN)) u_mon (
    .clk(clk), .rst(rst), .clr(!in_lock), .en(in_lock),
    .bit_i(ud_raw), .reach(mon_reach));

  assign enter_lock = in_chk && acq_reach;

  dscr_hold_timer #(.HOLD(HOLD_BITS)) u_hold (
    .clk(clk), .rst(rst), .load(enter_lock), .en(in_lock),
    .reload(mon_reach), .expire(expire));

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_SEED:  if (seed_last) state_nx = ST_CHECK;
      ST_CHECK: begin
        if (!ud_raw)        state_nx = ST_SEED;
        else if (acq_reach) state_nx = ST_LOCK;
      end
      ST_LOCK:  if (expire) state_nx = ST_SEED;
      default:  state_nx = ST_SEED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SEED;
      seed_cnt_q <= '0;
    end else begin
      state_q    <= state_nx;
      seed_cnt_q <= (!in_seed || seed_last) ? '0 : seed_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ud_o       <= 1'b0;
      ud_valid_o <= 1'b0;
      locked_o   <= 1'b0;
    end else begin
      ud_valid_o <= in_lock && !expire;
      ud_o       <= (in_lock && !expire) ? ud_raw : 1'b0;
      locked_o   <= (state_nx == ST_LOCK);
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!locked_o && !ud_valid_o && !ud_o));
  // R6
  valid_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ud_valid_o |-> locked_o);
  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> ($past(state_q) == ST_CHECK) && $past(ud_raw));
  // R5
  acq_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (in_chk && !ud_raw) |=> (in_seed && seed_cnt_q == '0));
  // R9
  drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> $past(expire));
endmodule

// File: tb/fx_descrambler_bench.sv
module fx_descrambler_bench;
  localparam int HOLD = 200;
  localparam int IDLE = 58;
  localparam int ACQ  = 60;
  localparam int W    = 11;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd  = 1'b0;
  logic ud, vld, lck;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic kb [0:1023];
  logic pb [0:1023];

  always #2.5 clk = ~clk;

  fx_descrambler #(
    .LFSR_W(W), .LFSR_TAP(9), .ACQ_ONES(ACQ), .IDLE_MIN(IDLE), .HOLD_BITS(HOLD)
  ) u_fx_descrambler (
    .clk(clk), .rst(rst), .sd_i(sd), .ud_o(ud), .ud_valid_o(vld), .locked_o(lck));

  // kind 0: idle, then data with a zero every 16 bits (no reload) -> expiry
  // kind 1: idle with one zero at bit 30 during the ones check, then idle forever
  // kind 2: idle long enough for one reload at bit 128, then data -> expiry
  function automatic logic plain_of(int kind, int i);
    case (kind)
      0: return (i <= 70) ? 1'b1 : ((i % 16) != 0);
      1: return (i != 30);
      default: return (i <= 128) ? 1'b1 : ((i == 129) ? 1'b0 : ((i % 16) != 0));
    endcase
  endfunction

  task automatic build(int kind, int seed, int len);
    for (int j = 0; j < len; j++) begin
      if (j < W) kb[j] = seed[j];
      else       kb[j] = kb[j-11] ^ kb[j-9];
      pb[j] = plain_of(kind, j);
    end
  endtask

  task automatic check(string tag, logic act, logic exp, int i);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s bit %0d: got %b expected %b", tag, i, act, exp);
    end
  endtask

  task automatic scenario(int kind, int seed, int ls, int le, int len);
    string ltag;
    build(kind, seed, len);
    rst = 1'b1;
    sd  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", lck, 1'b0, -1);
    check("R1", vld, 1'b0, -1);
    check("R1", ud,  1'b0, -1);
    for (int i = 0; i < len; i++) begin
      logic exp_l, exp_v;
      @(negedge clk);
      rst = 1'b0;
      sd  = pb[i] ^ kb[i];
      @(posedge clk);
      #1;
      exp_l = (i >= ls) && (i < le);
      exp_v = (i > ls) && (i < le);
      if (i < ls)      ltag = (kind == 1) ? "R5" : "R4";
      else if (i < le) ltag = (kind == 2) ? "R8" : "R7";
      else             ltag = "R9";
      check(ltag, lck, exp_l, i);
      check("R6", vld, exp_v, i);
      // R2 and R3: bits after a correct seed equal the plain stream
      if (exp_v) check("R2/R3", ud, pb[i], i);
    end
  endtask

  initial begin
    scenario(0, 11'h5A3, 70, 70 + HOLD, 400);
    scenario(1, 11'h001, 101, NEVER, 101 + HOLD + 150);
    scenario(2, 11'h7FF, 70, 128 + HOLD, 128 + HOLD + 80);
    scenario(0, 11'h2C4, 70, 70 + HOLD, 400);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule